// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This block is a two-channel debug breakpoint unit that watches the stream of instructions a CPU actually executes. Each channel holds a compare address, a bus-cycle condition and a timing choice. When the condition is valid and an executing instruction's address matches, the channel raises a user break request, either ahead of that instruction or once it has completed. The bus-cycle condition covers the bus selected, fetch versus data, read versus write, and the access size.

Matching is done on the execute strobe. That strobe marks each instruction that is confirmed to execute and carries its PC. Instructions fetched by overrun are discarded around a branch or an interrupt transition and never reach the strobe, so they can never cause a break. A small tracker follows taken delayed branches. A break that falls on a delayed branch or its delay slot is held back until the first instruction at the branch target is strobed.

A request seen in cycle t means the break is taken before any instruction strobed in cycle t or later. Each channel keeps a sticky flag that software clears by writing 1. The request output is the OR of the enabled channels' pending requests.

Top module: `bkp_unit`

## Requirements
- R1: While reset is held, every channel's flag and deferred indicator read 0 at the next clock edge, and no request is pending.
- R2: Before mode (`ch_after_i`=0), match on an instruction that is not a delay slot: `brk_req_o` is high in the same cycle as that instruction's strobe, and the flag is set from the next cycle.
- R3: After mode (`ch_after_i`=1), match on an instruction that is neither a taken delayed branch nor a delay slot: `brk_req_o` stays low in the strobe cycle and is high from the following cycle.
- R4: A PC presented while `ex_valid_i` is 0 never matches. An overrun fetch is never strobed, so it never sets a flag or a request.
- R5: Before mode, match on the delay slot of a taken delayed branch: the request is held as deferred and becomes visible in the strobe cycle of the next executed instruction, which is the branch target.
- R6: After mode, match on a taken delayed branch (`ex_dbranch_i`=1 with `ex_taken_i`=1) or on its delay slot: the request becomes visible in the strobe cycle of the branch target.
- R7: When a delayed branch is strobed with `ex_taken_i`=0, the next instruction is not a delay slot and gets normal handling under R2 or R3.
- R8: When bit 0 of a channel's compare address is 1, that channel never raises a request.
- R9: A channel can match only when its condition is all of the following: CPU instruction bus (`ch_bus_i`=0), fetch (`ch_kind_i`=0), read (`ch_write_i`=0), and size word (2'b10) or longword (2'b11). The internal data bus, a data cycle, a write, size none (2'b00) or byte (2'b01) each make the channel never match.
- R10: A channel's flag is sticky until a write of 1 to its `flag_clr_i` bit. When a new match and a clear land in the same cycle, the flag stays set.
- R11: `brk_req_o` is the OR over enabled channels of their flags and same-cycle fires. A disabled channel contributes nothing, and disabling a channel cancels its deferred request.
- R12: The address comparison covers PC bits above bit 0. The PC's bit 0 is excluded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en_i | input | NCH | Per-channel enable |
| ch_addr_i | input | NCH x AW | Per-channel compare address |
| ch_bus_i | input | NCH | Bus select: 0 CPU instruction bus, 1 internal data bus |
| ch_kind_i | input | NCH | Cycle kind: 0 fetch, 1 data |
| ch_write_i | input | NCH | Direction: 0 read, 1 write |
| ch_size_i | input | NCH x 2 | Size: 00 none, 01 byte, 10 word, 11 longword |
| ch_after_i | input | NCH | 0 break before execution, 1 break after execution |
| flag_clr_i | input | NCH | Write-1-to-clear of the sticky flags |
| ex_valid_i | input | 1 | Strobe: an instruction is confirmed to execute this cycle |
| ex_pc_i | input | AW | Address of the strobed instruction |
| ex_dbranch_i | input | 1 | Strobed instruction is a delayed branch |
| ex_taken_i | input | 1 | The strobed delayed branch is taken |
| brk_req_o | output | 1 | User break request |
| flag_o | output | NCH | Sticky per-channel match flags |
| defer_o | output | NCH | Per-channel request waiting for the branch target |

## Verification
The assertions check several local rules on every cycle. Flags stay set without a clear, and no flag appears without a strobe. An after-mode or deferred fire always leaves the flag set. The tracker always moves from delay slot to target, a disabled channel never holds a deferred request, and an odd compare address or an invalid condition never produces a hit. The exact cycle in which the request becomes visible, relative to each strobe, can only be shown by the bench's scenarios. These cover every position of the match around a taken or not-taken delayed branch in both modes, and sweeps over all condition encodings and all PC values.

// File: rtl/bkp_pkg.sv
// Package: shared types and encodings for the breakpoint unit.
// Assumes: two-bit size codes, one-bit bus and kind selects.
package bkp_pkg;

    // Position of the next strobed instruction relative to a taken delayed branch.
    typedef enum logic [1:0] {
        SEQ_NORM = 2'd0,
        SEQ_SLOT = 2'd1,
        SEQ_TGT  = 2'd2
    } seq_e;

    localparam logic [1:0] SZ_NONE = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_LONG = 2'b11;

    localparam logic BUS_CPU    = 1'b0;
    localparam logic KIND_FETCH = 1'b0;

    // Bus-cycle condition of one channel, minus its address.
    typedef struct packed {
        logic       en;
        logic       bus;
        logic       kind;
        logic       write;
        logic [1:0] size;
        logic       after;
    } cfg_t;

endpackage

// File: rtl/bkp_cond_match.sv
// Module: bkp_cond_match
// Decides whether a channel's condition is a valid instruction-fetch break.
// If so, it compares the compare address with the strobed PC.
// Assumes: instructions are at least halfword aligned, so PC bit 0 is not compared.
module bkp_cond_match
    import bkp_pkg::*;
#(
    parameter int AW = 8
) (
    input  cfg_t          cfg_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:1] pc_hi_i,
    output logic          cond_ok_o,
    output logic          hit_o
);

    logic size_ok;
    logic addr_eq;

    // Only word and longword fetches are meaningful for instructions.
    always_comb begin
        unique case (cfg_i.size)
            SZ_WORD, SZ_LONG: size_ok = 1'b1;
            default:          size_ok = 1'b0;
        endcase
    end

    // Valid condition: enabled, CPU bus, fetch, read, legal size, even address.
    always_comb begin
        cond_ok_o = cfg_i.en
                  && (cfg_i.bus == BUS_CPU)
                  && (cfg_i.kind == KIND_FETCH)
                  && !cfg_i.write
                  && size_ok
                  && !addr_i[0];
    end

    // Compare the address above bit 0.
    always_comb begin
        addr_eq = (addr_i[AW-1:1] == pc_hi_i);
        hit_o   = cond_ok_o && addr_eq;
    end

endmodule

// File: rtl/bkp_slot_tracker.sv
// Module: bkp_slot_tracker
// Follows the executed-instruction stream and tells whether the current strobe
// is a delay slot or a branch target.
// Assumes: a delay slot never holds a branch, and strobes arrive in program order.
module bkp_slot_tracker
    import bkp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ex_valid_i,
    input  logic ex_dbranch_i,
    input  logic ex_taken_i,
    output logic in_slot_o,
    output logic at_target_o,
    output logic branch_now_o
);

    seq_e state_q;
    seq_e state_d;

    // Classify the currently strobed instruction from the tracked position.
    always_comb begin
        in_slot_o    = (state_q == SEQ_SLOT);
        at_target_o  = (state_q == SEQ_TGT);
        branch_now_o = ex_dbranch_i && ex_taken_i && (state_q != SEQ_SLOT);
    end

    // Advance position on every strobe.
    always_comb begin
        state_d = state_q;
        if (ex_valid_i) begin
            if (state_q == SEQ_SLOT) begin
                state_d = SEQ_TGT;
            end else if (ex_dbranch_i && ex_taken_i) begin
                state_d = SEQ_SLOT;
            end else begin
                state_d = SEQ_NORM;
            end
        end
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_NORM;
        end else begin
            state_q <= state_d;
        end
    end

    // R6: a taken delayed branch makes the next strobe a delay slot.
    p_slot_follows_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && ex_dbranch_i && ex_taken_i && state_q != SEQ_SLOT) |=> (state_q == SEQ_SLOT));

    // R5: the instruction after a delay slot is the branch target.
    p_target_after_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && state_q == SEQ_SLOT) |=> (state_q == SEQ_TGT));

    // R7: a not-taken delayed branch leaves normal handling in place.
    p_not_taken_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && state_q != SEQ_SLOT && !(ex_dbranch_i && ex_taken_i)) |=> (state_q == SEQ_NORM));

endmodule

// File: rtl/bkp_channel.sv
// Module: bkp_channel
// Per-channel break state: immediate fire, after-execution fire,
// the request deferred to the branch target, and the sticky flag.
// Assumes: hit_i already contains condition validity and address equality.
module bkp_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic after_i,
    input  logic addr_lsb_i,
    input  logic cond_ok_i,
    input  logic hit_i,
    input  logic ex_valid_i,
    input  logic in_slot_i,
    input  logic at_target_i,
    input  logic branch_now_i,
    input  logic clr_i,
    output logic req_o,
    output logic flag_o,
    output logic defer_o
);

    logic flag_q;
    logic defer_q;
    logic hit_now;
    logic defer_set;
    logic before_now;
    logic after_norm;
    logic tgt_fire;
    logic fire_now;

    // Classify a match by mode and by position around a delayed branch.
    always_comb begin
        hit_now    = ex_valid_i && hit_i;
        defer_set  = hit_now && (after_i ? (in_slot_i || branch_now_i) : in_slot_i);
        before_now = hit_now && !after_i && !in_slot_i;
        after_norm = hit_now && after_i && !in_slot_i && !branch_now_i;
        tgt_fire   = ex_valid_i && at_target_i && defer_q;
        fire_now   = before_now || tgt_fire;
    end

    // Deferred request: dropped on disable, released at the target strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            defer_q <= 1'b0;
        end else begin
            defer_q <= en_i && (defer_set || (defer_q && !tgt_fire));
        end
    end

    // Sticky flag: set by any fire, cleared by write of 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= (flag_q && !clr_i) || fire_now || after_norm;
        end
    end

    // Request contribution of this channel.
    always_comb begin
        req_o   = en_i && (flag_q || fire_now);
        flag_o  = flag_q;
        defer_o = defer_q;
    end

    // R10: a set flag stays set unless cleared.
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_o);

    // R4: without a strobe no new flag appears.
    p_no_strobe_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !ex_valid_i) |=> !flag_o);

    // R3: an after-mode normal match leaves the flag set next cycle.
    p_after_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && hit_i && after_i && !in_slot_i && !branch_now_i) |=> flag_o);

    // R5: a deferred request released at the target leaves the flag set.
    p_target_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && at_target_i && defer_q) |=> flag_o);

    // R11: a disabled channel holds no deferred request.
    p_disable_cancels_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !defer_o);

    // R8: an odd compare address never hits.
    p_odd_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_lsb_i |-> !hit_i);

    // R9: an invalid condition never hits.
    p_bad_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_ok_i |-> !hit_i);

endmodule

// File: rtl/bkp_unit.sv
// Module: bkp_unit (top)
// Multi-channel instruction-fetch breakpoint unit. One tracker is shared by all
// channels; each channel has its own condition check and state.
// Assumes: ex_valid_i marks only instructions confirmed to execute, in order.
module bkp_unit
    import bkp_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           ch_en_i,
    input  logic [NCH-1:0][AW-1:0]   ch_addr_i,
    input  logic [NCH-1:0]           ch_bus_i,
    input  logic [NCH-1:0]           ch_kind_i,
    input  logic [NCH-1:0]           ch_write_i,
    input  logic [NCH-1:0][1:0]      ch_size_i,
    input  logic [NCH-1:0]           ch_after_i,
    input  logic [NCH-1:0]           flag_clr_i,
    input  logic                     ex_valid_i,
    input  logic [AW-1:0]            ex_pc_i,
    input  logic                     ex_dbranch_i,
    input  logic                     ex_taken_i,
    output logic                     brk_req_o,
    output logic [NCH-1:0]           flag_o,
    output logic [NCH-1:0]           defer_o
);

    logic           in_slot;
    logic           at_target;
    logic           branch_now;
    logic [NCH-1:0] req_vec;
    logic           pc_lsb_unused;

    // PC bit 0 plays no part in matching.
    assign pc_lsb_unused = ex_pc_i[0];

    bkp_slot_tracker u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .ex_valid_i   (ex_valid_i),
        .ex_dbranch_i (ex_dbranch_i),
        .ex_taken_i   (ex_taken_i),
        .in_slot_o    (in_slot),
        .at_target_o  (at_target),
        .branch_now_o (branch_now)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cfg_t cfg;
        logic cond_ok;
        logic hit;

        // Gather this channel's condition fields.
        always_comb begin
            cfg.en    = ch_en_i[c];
            cfg.bus   = ch_bus_i[c];
            cfg.kind  = ch_kind_i[c];
            cfg.write = ch_write_i[c];
            cfg.size  = ch_size_i[c];
            cfg.after = ch_after_i[c];
        end

        bkp_cond_match #(.AW(AW)) u_cond (
            .cfg_i     (cfg),
            .addr_i    (ch_addr_i[c]),
            .pc_hi_i   (ex_pc_i[AW-1:1]),
            .cond_ok_o (cond_ok),
            .hit_o     (hit)
        );

        bkp_channel u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (cfg.en),
            .after_i      (cfg.after),
            .addr_lsb_i   (ch_addr_i[c][0]),
            .cond_ok_i    (cond_ok),
            .hit_i        (hit),
            .ex_valid_i   (ex_valid_i),
            .in_slot_i    (in_slot),
            .at_target_i  (at_target),
            .branch_now_i (branch_now),
            .clr_i        (flag_clr_i[c]),
            .req_o        (req_vec[c]),
            .flag_o       (flag_o[c]),
            .defer_o      (defer_o[c])
        );
    end

    // Combined break request.
    assign brk_req_o = |req_vec;

    // R1: reset leaves no flag and no deferred request.
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (flag_o == '0 && defer_o == '0));

    // R11: with every channel disabled there is no request.
    p_no_req_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en_i == '0) |-> !brk_req_o);

endmodule

// File: tb/sim_bkp_unit.sv
`timescale 1ns/1ps
module sim_bkp_unit;

    localparam int NCH = 2;
    localparam int AW  = 8;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [NCH-1:0]         ch_en;
    logic [NCH-1:0][AW-1:0] ch_addr;
    logic [NCH-1:0]         ch_bus;
    logic [NCH-1:0]         ch_kind;
    logic [NCH-1:0]         ch_write;
    logic [NCH-1:0][1:0]    ch_size;
    logic [NCH-1:0]         ch_after;
    logic [NCH-1:0]         flag_clr;
    logic                   ex_valid;
    logic [AW-1:0]          ex_pc;
    logic                   ex_dbranch;
    logic                   ex_taken;
    logic                   brk_req;
    logic [NCH-1:0]         flag;
    logic [NCH-1:0]         defer;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bkp_unit #(.NCH(NCH), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en), .ch_addr_i(ch_addr),
        .ch_bus_i(ch_bus), .ch_kind_i(ch_kind), .ch_write_i(ch_write),
        .ch_size_i(ch_size), .ch_after_i(ch_after), .flag_clr_i(flag_clr),
        .ex_valid_i(ex_valid), .ex_pc_i(ex_pc), .ex_dbranch_i(ex_dbranch),
        .ex_taken_i(ex_taken), .brk_req_o(brk_req), .flag_o(flag), .defer_o(defer)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge; sample 1 ns later, well before the rising edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ex_valid = 0; ex_pc = '0; ex_dbranch = 0; ex_taken = 0; flag_clr = '0;
    endtask

    task automatic do_reset();
        step(); idle_inputs(); rst_n = 0;
        step(); step(); rst_n = 1;
    endtask

    // Channel 0 valid fetch condition; channel 1 disabled.
    task automatic cfg_good(input logic [AW-1:0] a, input logic aft);
        ch_en = 2'b01; ch_addr[0] = a; ch_addr[1] = '0;
        ch_bus = '0; ch_kind = '0; ch_write = '0;
        ch_size[0] = 2'b10; ch_size[1] = 2'b10; ch_after = {1'b0, aft};
    endtask

    task automatic strobe(input logic [AW-1:0] pc, input logic db, input logic tk);
        step(); ex_valid = 1; ex_pc = pc; ex_dbranch = db; ex_taken = tk; flag_clr = '0;
        #1;
    endtask

    task automatic quiet();
        step(); idle_inputs(); #1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        idle_inputs();
        cfg_good(8'h10, 1'b0);
        rst_n = 0;
        step(); step();
        // R1: reset state
        #1;
        check("R1 flags", {6'd0, flag}, 8'd0);
        check("R1 defer", {6'd0, defer}, 8'd0);
        check("R1 req", {7'd0, brk_req}, 8'd0);
        rst_n = 1;

        // R9 and R8: sweep every condition encoding, before mode, PC equal to address.
        for (int i = 0; i < 64; i++) begin
            logic [1:0] sz;
            logic bus, knd, wr, a0, exp;
            sz = i[1:0]; bus = i[2]; knd = i[3]; wr = i[4]; a0 = i[5];
            do_reset();
            cfg_good({7'h2C, a0}, 1'b0);
            ch_bus[0] = bus; ch_kind[0] = knd; ch_write[0] = wr; ch_size[0] = sz;
            exp = !bus && !knd && !wr && (sz >= 2'd2) && !a0;
            strobe(8'h58, 0, 0);
            check(a0 ? "R8 odd address" : "R9 condition", {7'd0, brk_req}, {7'd0, exp});
        end

        // R12 and R2: sweep all PC values against address 0x5A.
        do_reset();
        cfg_good(8'h5A, 1'b0);
        for (int p = 0; p < 256; p++) begin
            logic exp;
            exp = (p[7:1] == 7'h2D);
            strobe(p[7:0], 0, 0);
            check("R12 pc compare", {7'd0, brk_req}, {7'd0, exp});
            step(); idle_inputs(); flag_clr = 2'b11;
            step(); flag_clr = '0;
        end

        // R2 R3 R5 R6 R7: match position around a delayed branch, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [AW-1:0] pcs [4];
                    int e;
                    pcs[0] = 8'h10; pcs[1] = 8'h12; pcs[2] = 8'h40; pcs[3] = 8'h42;
                    if (m == 0) e = (t == 1 && k == 1) ? 2 : k;
                    else        e = (t == 1 && k <= 1) ? 2 : k + 1;
                    do_reset();
                    cfg_good(pcs[k], m[0]);
                    for (int j = 0; j < 5; j++) begin
                        logic exp;
                        if (j < 4) strobe(pcs[j], j == 0, (j == 0) && t[0]);
                        else       quiet();
                        exp = (j >= e);
                        if (m == 0 && t == 1 && k == 1) check("R5 slot deferral", {7'd0, brk_req}, {7'd0, exp});
                        else if (m == 1 && t == 1 && k <= 1) check("R6 after deferral", {7'd0, brk_req}, {7'd0, exp});
                        else if (t == 0 && k == 1) check("R7 not taken", {7'd0, brk_req}, {7'd0, exp});
                        else if (m == 0) check("R2 before", {7'd0, brk_req}, {7'd0, exp});
                        else check("R3 after", {7'd0, brk_req}, {7'd0, exp});
                    end
                end
            end
        end

        // R4: matching PC without a strobe.
        do_reset();
        cfg_good(8'h20, 1'b0);
        step(); ex_valid = 0; ex_pc = 8'h20; #1;
        check("R4 no strobe req", {7'd0, brk_req}, 8'd0);
        quiet();
        check("R4 no strobe flag", {6'd0, flag}, 8'd0);

        // R10: sticky flag, clear, and set-wins.
        strobe(8'h20, 0, 0);
        quiet(); quiet();
        check("R10 sticky", {6'd0, flag}, 8'd1);
        step(); flag_clr = 2'b01; step(); flag_clr = '0; #1;
        check("R10 cleared", {6'd0, flag}, 8'd0);
        step(); ex_valid = 1; ex_pc = 8'h20; flag_clr = 2'b01;
        step(); idle_inputs(); #1;
        check("R10 set wins", {6'd0, flag}, 8'd1);

        // R11: disable masks request; re-enable shows sticky flag; channel 1 alone.
        step(); ch_en = 2'b00; #1;
        check("R11 masked", {7'd0, brk_req}, 8'd0);
        step(); ch_en = 2'b01; #1;
        check("R11 unmasked", {7'd0, brk_req}, 8'd1);
        do_reset();
        cfg_good(8'h20, 1'b0);
        ch_en = 2'b10; ch_addr[1] = 8'h30;
        strobe(8'h30, 0, 0);
        check("R11 channel 1", {7'd0, brk_req}, 8'd1);
        quiet();
        check("R11 channel 1 flag", {6'd0, flag}, 8'd2);

        // R11: disabling cancels a deferred request.
        do_reset();
        cfg_good(8'h12, 1'b0);
        strobe(8'h10, 1, 1);
        strobe(8'h12, 0, 0);
        quiet();
        check("R11 deferred held", {6'd0, defer}, 8'd1);
        step(); ch_en = 2'b00;
        step(); ch_en = 2'b01; #1;
        check("R11 deferred cancelled", {6'd0, defer}, 8'd0);
        strobe(8'h40, 0, 0);
        check("R11 no target fire", {7'd0, brk_req}, 8'd0);
        quiet();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule